// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds sixteen 48-bit performance counters behind a 32-bit register bus. Each counter picks one of 256 single-cycle event lines with an 8-bit code. It adds one in every cycle where that line pulses and where counting is switched on both globally and for that counter. When a counter rolls over from all ones to zero, it latches a pending flag. An interrupt output is raised for any pending flag that software has not masked.

Software programs the event codes, clears or preloads the counters, and sets the enables. It reads the counts back as two 32-bit words. It services interrupts by reading the pending flags and writing ones to a separate acknowledge register. The bus is a simple single-cycle select/write strobe with word addresses, and read data is returned combinationally from the addressed register.

Top module: `evt_ctr_unit`

## Requirements
- R1: After reset, every counter, the global run bit, the per-counter enables and the pending flags read zero. The mask register reads 0x0000FFFF, every select word reads 0xFFFFFFFF (all codes 0xFF), and `irq` is low.
- R2: Counter i occupies the low word at byte address 0x1F00+8*i (count bits 31:0) and the high word at 0x1F04+8*i (count bits 47:32 in bits 15:0). Bits 31:16 of the high word always read zero, and writes to them are ignored.
- R3: The code of counter i is held in the select word at 0x1E80+4*(i/4), in bits 8*(i%4)+7 down to 8*(i%4), and it reads back as written.
- R4: A counter adds exactly one on each clock where the event line indexed by its code is high, bit 0 of the run register at 0x1E00 is set, and bit i of the enable register at 0x1E04 is set. In any other cycle it holds its value.
- R5: A counter whose code is 0xFF never counts, even when event line 255 pulses.
- R6: When a counting counter is at 2^48-1, it becomes zero at the next edge, and pending bit i, read at 0x0808, becomes 1 at that same edge.
- R7: Writing to the acknowledge register at 0x080C clears the pending bits written as 1 and leaves those written as 0 unchanged. The register reads as zero. A rollover in the same cycle as its acknowledge leaves the bit set.
- R8: Mask register 0x0804 bit i set to 1 blocks counter i from the interrupt. `irq` is high exactly when some pending bit has its mask bit at 0.
- R9: A bus write to a counter word in the same cycle as a counted event stores the written value without the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 16 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| evt_in | input | 256 | Event pulse lines indexed by event code |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest conditions to reach are the rollover and the collisions around it. From reset, a rollover would take 2^48 events. The stimulus therefore preloads a counter to all ones through both words of its slot and then fires a single event. In the same way, the acknowledge-versus-rollover race and the write-versus-event race are reached by one cycle that drives a bus write and an event line together. Isolation between counters is shown by giving each counter a distinct code, sending a different number of pulses on each line, and reading back all sixteen counts.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] OFS_RUN    = 16'h1E00;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 16'h1E04;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 16'h0804;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 16'h0808;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 16'h080C;
    localparam logic [ADDR_W-1:0] OFS_SEL    = 16'h1E80;
    localparam logic [ADDR_W-1:0] OFS_CNT    = 16'h1F00;
    localparam logic [7:0]        CODE_NONE  = 8'hFF;
endpackage

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice #(
    parameter int CTR_W  = 48,
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2**CODE_W-1:0] evt_in,
    input  logic [CODE_W-1:0]    code,
    input  logic                 run,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [DATA_W-1:0]    wdata,
    output logic [CTR_W-1:0]     count,
    output logic                 wrap
);
    localparam int HI_W = CTR_W - DATA_W;

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } slice_t;

    slice_t s_d, s_q;
    logic   hit;
    logic   wr_any;

    always_comb begin
        s_d    = s_q;
        wr_any = wr_lo | wr_hi;
        hit    = run && (code != {CODE_W{1'b1}}) && evt_in[code];
        wrap   = 1'b0;
        if (wr_any) begin
            if (wr_lo) s_d.cnt[DATA_W-1:0]     = wdata;
            if (wr_hi) s_d.cnt[CTR_W-1:DATA_W] = wdata[HI_W-1:0];
        end else if (hit) begin
            s_d.cnt = s_q.cnt + 1'b1;
            wrap    = (s_q.cnt == {CTR_W{1'b1}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count));
    // R5
    none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((code == {CODE_W{1'b1}}) && !wr_lo && !wr_hi) |=> $stable(count));
    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));
    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[DATA_W-1:0] == $past(wdata)));
endmodule

// File: rtl/evt_ctr_regs.sv
module evt_ctr_regs
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 16,
    parameter int CODE_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [NUM_CTR-1:0]        wrap,
    output logic                      run_all,
    output logic [NUM_CTR-1:0]        enable,
    output logic [NUM_CTR-1:0]        mask,
    output logic [NUM_CTR-1:0]        pend,
    output logic [NUM_CTR*CODE_W-1:0] codes,
    output logic                      irq
);
    localparam int PER_WORD = DATA_W / CODE_W;
    localparam int NUM_SEL  = NUM_CTR / PER_WORD;
    localparam int WA_W     = ADDR_W - 2;
    localparam logic [WA_W-1:0] WA_RUN  = OFS_RUN[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_EN   = OFS_ENABLE[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_MASK = OFS_MASK[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_ACK  = OFS_ACK[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_SEL  = OFS_SEL[ADDR_W-1:2];

    typedef struct packed {
        logic                      run;
        logic [NUM_CTR-1:0]        en;
        logic [NUM_CTR-1:0]        msk;
        logic [NUM_CTR-1:0]        st;
        logic [NUM_CTR*CODE_W-1:0] cd;
    } regs_t;

    regs_t            r_d, r_q;
    logic [WA_W-1:0]  waddr;
    logic             wr;
    logic             ack_wr;

    always_comb begin
        r_d    = r_q;
        waddr  = bus_addr[ADDR_W-1:2];
        wr     = bus_sel && bus_we;
        ack_wr = wr && (waddr == WA_ACK);
        if (wr) begin
            if (waddr == WA_RUN)  r_d.run = bus_wdata[0];
            if (waddr == WA_EN)   r_d.en  = bus_wdata[NUM_CTR-1:0];
            if (waddr == WA_MASK) r_d.msk = bus_wdata[NUM_CTR-1:0];
            for (int k = 0; k < NUM_SEL; k++) begin
                if (waddr == WA_SEL + WA_W'(k)) begin
                    for (int l = 0; l < PER_WORD; l++) begin
                        r_d.cd[(k*PER_WORD+l)*CODE_W +: CODE_W] = bus_wdata[l*CODE_W +: CODE_W];
                    end
                end
            end
        end
        if (ack_wr) r_d.st = r_q.st & ~bus_wdata[NUM_CTR-1:0];
        r_d.st = r_d.st | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.run <= 1'b0;
            r_q.en  <= '0;
            r_q.msk <= '1;
            r_q.st  <= '0;
            r_q.cd  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_all = r_q.run;
    assign enable  = r_q.en;
    assign mask    = r_q.msk;
    assign pend    = r_q.st;
    assign codes   = r_q.cd;
    assign irq     = |(r_q.st & ~r_q.msk);

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap != '0) |=> ((pend & $past(wrap)) == $past(wrap)));
    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && (wrap == '0)) |=> ((pend & $past(bus_wdata[NUM_CTR-1:0])) == '0));
    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((pend & ~$past(bus_wdata[NUM_CTR-1:0])) == ($past(pend) & ~$past(bus_wdata[NUM_CTR-1:0]))) || ($past(wrap) != '0));
endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR = 16,
    parameter int CTR_W   = 48,
    parameter int CODE_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [15:0]          bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [2**CODE_W-1:0] evt_in,
    output logic                 irq
);
    localparam int PER_WORD = DATA_W / CODE_W;
    localparam int NUM_SEL  = NUM_CTR / PER_WORD;
    localparam int HI_W     = CTR_W - DATA_W;
    localparam int WA_W     = ADDR_W - 2;
    localparam logic [WA_W-1:0] WA_RUN  = OFS_RUN[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_EN   = OFS_ENABLE[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_MASK = OFS_MASK[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_PEND = OFS_PEND[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_SEL  = OFS_SEL[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WA_CNT  = OFS_CNT[ADDR_W-1:2];

    logic                      run_all;
    logic [NUM_CTR-1:0]        enable, mask, pend, wrap;
    logic [NUM_CTR*CODE_W-1:0] codes;
    logic [CTR_W-1:0]          count [NUM_CTR];
    logic [NUM_CTR-1:0]        wr_lo, wr_hi;
    logic [WA_W-1:0]           waddr;

    assign waddr = bus_addr[ADDR_W-1:2];

    evt_ctr_regs #(
        .NUM_CTR(NUM_CTR), .CODE_W(CODE_W), .DATA_W(DATA_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wrap(wrap), .run_all(run_all), .enable(enable), .mask(mask),
        .pend(pend), .codes(codes), .irq(irq)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        assign wr_lo[i] = bus_sel && bus_we && (waddr == WA_CNT + WA_W'(2*i));
        assign wr_hi[i] = bus_sel && bus_we && (waddr == WA_CNT + WA_W'(2*i+1));

        evt_ctr_slice #(
            .CTR_W(CTR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)
        ) i_slice (
            .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
            .code(codes[i*CODE_W +: CODE_W]),
            .run(run_all && enable[i]),
            .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
            .count(count[i]), .wrap(wrap[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (waddr == WA_RUN)  bus_rdata[0] = run_all;
        if (waddr == WA_EN)   bus_rdata[NUM_CTR-1:0] = enable;
        if (waddr == WA_MASK) bus_rdata[NUM_CTR-1:0] = mask;
        if (waddr == WA_PEND) bus_rdata[NUM_CTR-1:0] = pend;
        for (int k = 0; k < NUM_SEL; k++) begin
            if (waddr == WA_SEL + WA_W'(k))
                bus_rdata = codes[k*DATA_W +: DATA_W];
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (waddr == WA_CNT + WA_W'(2*i))
                bus_rdata = count[i][DATA_W-1:0];
            if (waddr == WA_CNT + WA_W'(2*i+1))
                bus_rdata[HI_W-1:0] = count[i][CTR_W-1:DATA_W];
        end
    end

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);
    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);
endmodule

// File: tb/test_evt_ctr_unit.sv
module test_evt_ctr_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] evt_in = '0;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    longint exp_cnt [16];

    always #4 clk = ~clk;

    evt_ctr_unit i_evt_ctr_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    function automatic logic [7:0] code_of(int i);
        return 8'(i * 7 + 2);
    endfunction

    task automatic check(string req, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(bit do_wr, logic [15:0] a, logic [31:0] d, logic [255:0] ev);
        @(negedge clk);
        bus_sel = do_wr; bus_we = do_wr; bus_addr = a; bus_wdata = d; evt_in = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; evt_in = '0;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        cyc(1'b1, a, d, '0);
    endtask

    task automatic pulse(logic [255:0] ev);
        cyc(1'b0, 16'h0, 32'h0, ev);
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(int i, output longint v);
        logic [31:0] lo, hi;
        rd(16'h1F00 + 16'(8*i), lo);
        rd(16'h1F04 + 16'(8*i), hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        longint v;
        logic [255:0] all_ev;
        logic [31:0] en_word;
        all_ev = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(16'h1E00, d); check("R1 run", d, 0);
        rd(16'h1E04, d); check("R1 enable", d, 0);
        rd(16'h0804, d); check("R1 mask", d, 32'h0000FFFF);
        rd(16'h0808, d); check("R1 pending", d, 0);
        for (int k = 0; k < 4; k++) begin
            rd(16'h1E80 + 16'(4*k), d); check("R1 select", d, 32'hFFFFFFFF);
        end
        for (int i = 0; i < 16; i++) begin
            rd_cnt(i, v); check("R1 counter", v, 0);
            exp_cnt[i] = 0;
        end
        check("R1 irq", irq, 0);

        // R5 all lines pulse while codes are 0xFF and everything enabled
        wr(16'h1E04, 32'hFFFF);
        wr(16'h1E00, 32'h1);
        pulse(all_ev);
        rd_cnt(0, v); check("R5 none code", v, 0);

        // R3 program packed codes and read them back
        for (int k = 0; k < 4; k++)
            wr(16'h1E80 + 16'(4*k), {code_of(4*k+3), code_of(4*k+2), code_of(4*k+1), code_of(4*k)});
        for (int k = 0; k < 4; k++) begin
            rd(16'h1E80 + 16'(4*k), d);
            check("R3 select word", d, {code_of(4*k+3), code_of(4*k+2), code_of(4*k+1), code_of(4*k)});
        end

        // R4 distinct pulse counts per counter
        for (int i = 0; i < 16; i++) begin
            for (int p = 0; p <= i; p++) begin
                logic [255:0] ev;
                ev = '0; ev[code_of(i)] = 1'b1;
                pulse(ev);
            end
            exp_cnt[i] += i + 1;
        end
        for (int i = 0; i < 16; i++) begin
            rd_cnt(i, v); check("R4 isolated count", v, exp_cnt[i]);
        end

        // R4 global run off: nothing counts
        wr(16'h1E00, 32'h0);
        pulse(all_ev);
        rd_cnt(7, v); check("R4 run off", v, exp_cnt[7]);

        // R4 one counter disabled
        wr(16'h1E00, 32'h1);
        en_word = 32'hFFFF & ~32'h8;
        wr(16'h1E04, en_word);
        pulse(all_ev);
        for (int i = 0; i < 16; i++) if (en_word[i]) exp_cnt[i] += 1;
        for (int i = 0; i < 16; i++) begin
            rd_cnt(i, v); check("R4 per-counter enable", v, exp_cnt[i]);
        end
        wr(16'h1E04, 32'hFFFF);

        // R5 code 0xFF on counter 0 with line 255 active
        wr(16'h1E80, {code_of(3), code_of(2), code_of(1), 8'hFF});
        pulse(all_ev);
        for (int i = 1; i < 16; i++) exp_cnt[i] += 1;
        rd_cnt(0, v); check("R5 code FF", v, exp_cnt[0]);
        rd_cnt(1, v); check("R5 neighbour counts", v, exp_cnt[1]);

        // R2 slot layout and ignored upper bits
        wr(16'h1F2C, 32'hFFFFFFFF);
        wr(16'h1F28, 32'hFFFFFFFF);
        rd(16'h1F2C, d); check("R2 high word", d, 32'h0000FFFF);
        rd(16'h1F28, d); check("R2 low word", d, 32'hFFFFFFFF);

        // R6 rollover
        begin
            logic [255:0] ev;
            ev = '0; ev[code_of(5)] = 1'b1;
            pulse(ev);
        end
        rd_cnt(5, v); check("R6 wrap to zero", v, 0);
        rd(16'h0808, d); check("R6 pending", d, 32'h20);
        check("R8 masked irq", irq, 0);

        // R8 unmask
        wr(16'h0804, 32'hFFFF & ~32'h20);
        check("R8 irq on", irq, 1);
        wr(16'h0804, 32'hFFFF & ~32'h40);
        check("R8 other unmasked", irq, 0);
        wr(16'h0804, 32'hFFFF & ~32'h20);

        // R7 acknowledge
        wr(16'h080C, 32'hFFFF & ~32'h20);
        rd(16'h0808, d); check("R7 zero bits keep", d, 32'h20);
        rd(16'h080C, d); check("R7 ack reads zero", d, 0);
        wr(16'h080C, 32'h20);
        rd(16'h0808, d); check("R7 cleared", d, 0);
        check("R8 irq off", irq, 0);

        // R7 rollover in the same cycle as acknowledge
        wr(16'h1F2C, 32'h0000FFFF);
        wr(16'h1F28, 32'hFFFFFFFF);
        begin
            logic [255:0] ev;
            ev = '0; ev[code_of(5)] = 1'b1;
            cyc(1'b1, 16'h080C, 32'h20, ev);
        end
        rd(16'h0808, d); check("R7 wrap beats ack", d, 32'h20);
        check("R8 irq after race", irq, 1);
        wr(16'h080C, 32'h20);

        // R9 write and event together
        begin
            logic [255:0] ev;
            ev = '0; ev[code_of(2)] = 1'b1;
            cyc(1'b1, 16'h1F10, 32'd100, ev);
            rd(16'h1F10, d); check("R9 write wins", d, 100);
            pulse(ev);
            rd(16'h1F10, d); check("R9 counts after", d, 101);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule